// File: doc/BRIEF.md
# Fixed-Slot Pipeline Hazard Interlock

This block is the issue and interlock unit of an eight-stage in-order pipeline that runs a small set of 8-bit accumulator instructions. Each instruction spends exactly eight cycles in the pipeline and touches each resource in one fixed stage only. Zero-page memory is read in stage 3 and stored in stage 8. The X and Y index registers are read in stage 4 and written in stage 7. The accumulator is both read and written in stage 7. Because these stages are fixed, a dependency is found by comparing stage positions. The unit never has to forward a value.

A decoder in front of the unit offers one instruction descriptor at a time. The descriptor holds a read mask, a write mask and an 8-bit zero-page address. Each cycle the unit compares the offered descriptor with every older instruction still in flight. If the new instruction would read a resource before an older instruction has written it, the unit stalls: the offer is held and a bubble enters stage 1, while older instructions keep moving. Otherwise the unit issues the instruction into stage 1. With no conflicts, one instruction issues and one completes every cycle, so eight are in flight.

Top module: `fixed_slot_interlock`

## Requirements
- R1: A synchronous active-high reset clears every bit of `stage_valid`. This holds whether or not instructions are in flight.
- R2: Each cycle, `stage_valid` shifts up by one bit. Bit 0 is stage 1, and bit 7 (stage 8) drops out. Bit 0 takes the value of `issue` from the previous cycle. With no conflicts, eight back-to-back offers issue with no stall and fill the vector to 8'hFF.
- R3: `issue` and `stall` are never high together, and both are low while `in_valid` is low. A stall cycle puts a bubble (bit 0 = 0) into stage 1 while older instructions advance.
- R4: Mask bit 3 marks zero-page access. An offer that reads zero-page address Z stalls while an older valid instruction that stores to Z sits in stages 1 to 5. An offer right behind such a store therefore stalls for 5 cycles. Each idle cycle between the two removes one stall cycle.
- R5: Zero-page reads and stores to different addresses never stall.
- R6: Mask bits 1 (X) and 2 (Y) mark the index registers. An offer that reads X or Y stalls while an older valid instruction that writes the same register sits in stages 1 to 3. That is 3 stall cycles when the two are back to back.
- R7: Mask bit 0 marks the accumulator. An accumulator write followed at once by an accumulator read never stalls.
- R8: A bubble never causes a stall, whatever descriptor values were on the inputs when it entered.
- R9: Only a write by an older instruction followed by a read by the new one is a conflict. A read followed by a write, or a write followed by a write, never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction descriptor is offered |
| in_rd | input | 4 | Read mask: bit0 A, bit1 X, bit2 Y, bit3 zero-page |
| in_wr | input | 4 | Write mask, same bit layout |
| in_zp | input | 8 | Zero-page address that the offered instruction reads or stores |
| issue | output | 1 | The offer enters stage 1 at the next edge |
| stall | output | 1 | The offer is held and a bubble enters stage 1 |
| stage_valid | output | 8 | Occupancy of stages 1 to 8 (bit 0 is stage 1) |

## Verification
The bench measures how many cycles each offer waits, with the conflicting store placed 0, 4 and 5 cycles ahead, so that it covers both edges of each stall window. A window that is one stage too short lets a load read stale memory. A window that is one stage too long costs a cycle that shows up as a wrong stall count. Other tests cover an address mismatch, a read-then-write or write-then-write pair, and an accumulator pair. These pairs must issue at once, so a design that compares the wrong mask or ignores the address shows extra stalls. A bubble entered while conflicting descriptor values sat on the inputs must not block a later read. The stage vector is checked after stalls and after a reset in the middle of a run, to show that bubbles land in stage 1 and that no instruction survives the reset.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  // Resource mask layout shared by read and write masks.
  localparam int RES_N  = 4;
  localparam int RES_A  = 0;
  localparam int RES_X  = 1;
  localparam int RES_Y  = 2;
  localparam int RES_ZP = 3;
  localparam int ZP_AW  = 8;

  typedef struct packed {
    logic [RES_N-1:0] rd;
    logic [RES_N-1:0] wr;
    logic [ZP_AW-1:0] zp;
  } slot_desc_t;
endpackage

// File: rtl/fsi_stage_chain.sv
module fsi_stage_chain
  import fsi_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int DESC_DEPTH = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enter,
  input  slot_desc_t                    enter_desc,
  output logic [N_STAGES-1:0]           valid_q,
  output slot_desc_t [DESC_DEPTH-1:0]   desc_q
);
  // Occupancy shifts every cycle; a non-entering cycle shifts in a bubble.
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= {valid_q[N_STAGES-2:0], enter};
  end

  // Descriptors are kept only as deep as the widest hazard window and carry
  // no reset: a stage's descriptor is meaningful only when its valid bit is set.
  generate
    if (DESC_DEPTH > 1) begin : g_deep
      always_ff @(posedge clk) desc_q <= {desc_q[DESC_DEPTH-2:0], enter_desc};
    end else begin : g_one
      always_ff @(posedge clk) desc_q[0] <= enter_desc;
    end
  endgenerate

  // R2: every occupied stage moves up one position on each clock.
  generate
    for (genvar s = 0; s < N_STAGES-1; s++) begin : g_shift_chk
      a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        valid_q[s] |=> valid_q[s+1]);
    end
  endgenerate

  // R1: reset empties the pipeline on the following edge.
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (valid_q == '0));
endmodule

// File: rtl/fsi_slot_cmp.sv
module fsi_slot_cmp
  import fsi_pkg::*;
#(
  parameter int DIST    = 1,
  parameter int ZP_WIN  = 5,
  parameter int IDX_WIN = 3,
  parameter int ACC_WIN = 0
) (
  input  logic             older_valid,
  input  logic [RES_N-1:0] older_wr,
  input  logic [ZP_AW-1:0] older_zp,
  input  logic [RES_N-1:0] new_rd,
  input  logic [ZP_AW-1:0] new_zp,
  output logic             hit
);
  // A stage DIST ahead of the newcomer conflicts when its write lands no
  // earlier than the newcomer's read: DIST <= write_stage - read_stage.
  localparam bit ZP_ON  = (DIST <= ZP_WIN);
  localparam bit IDX_ON = (DIST <= IDX_WIN);
  localparam bit ACC_ON = (DIST <= ACC_WIN);

  logic zp_hit, x_hit, y_hit, a_hit;

  always_comb begin
    zp_hit = ZP_ON  && older_wr[RES_ZP] && new_rd[RES_ZP] && (older_zp == new_zp);
    x_hit  = IDX_ON && older_wr[RES_X]  && new_rd[RES_X];
    y_hit  = IDX_ON && older_wr[RES_Y]  && new_rd[RES_Y];
    a_hit  = ACC_ON && older_wr[RES_A]  && new_rd[RES_A];
    hit    = older_valid && (zp_hit || x_hit || y_hit || a_hit);
  end

  // R8: an empty stage never reports a conflict.
  always_comb begin
    a_r8_bubble_silent: assert (older_valid || !hit);
  end
endmodule

// File: rtl/fixed_slot_interlock.sv
module fixed_slot_interlock
  import fsi_pkg::*;
#(
  parameter int N_STAGES     = 8,
  parameter int ZP_RD_STAGE  = 3,
  parameter int ZP_WR_STAGE  = 8,
  parameter int IDX_RD_STAGE = 4,
  parameter int IDX_WR_STAGE = 7,
  parameter int ACC_RD_STAGE = 7,
  parameter int ACC_WR_STAGE = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [RES_N-1:0]    in_rd,
  input  logic [RES_N-1:0]    in_wr,
  input  logic [ZP_AW-1:0]    in_zp,
  output logic                issue,
  output logic                stall,
  output logic [N_STAGES-1:0] stage_valid
);
  localparam int ZP_WIN  = ZP_WR_STAGE  - ZP_RD_STAGE;
  localparam int IDX_WIN = IDX_WR_STAGE - IDX_RD_STAGE;
  localparam int ACC_WIN = ACC_WR_STAGE - ACC_RD_STAGE;
  localparam int WIN_MAX_RAW = (ZP_WIN > IDX_WIN)
                             ? ((ZP_WIN > ACC_WIN) ? ZP_WIN : ACC_WIN)
                             : ((IDX_WIN > ACC_WIN) ? IDX_WIN : ACC_WIN);
  // Only stages inside some window need descriptors and comparators.
  localparam int CMP_DEPTH = (WIN_MAX_RAW < 1) ? 1
                           : ((WIN_MAX_RAW > N_STAGES) ? N_STAGES : WIN_MAX_RAW);

  slot_desc_t                 new_desc;
  slot_desc_t [CMP_DEPTH-1:0] held_desc;
  logic       [CMP_DEPTH-1:0] stage_hit;
  logic                       hazard;

  assign new_desc = '{rd: in_rd, wr: in_wr, zp: in_zp};

  fsi_stage_chain #(
    .N_STAGES   (N_STAGES),
    .DESC_DEPTH (CMP_DEPTH)
  ) chain_i (
    .clk        (clk),
    .rst        (rst),
    .enter      (issue),
    .enter_desc (new_desc),
    .valid_q    (stage_valid),
    .desc_q     (held_desc)
  );

  generate
    for (genvar i = 0; i < CMP_DEPTH; i++) begin : g_cmp
      fsi_slot_cmp #(
        .DIST    (i + 1),
        .ZP_WIN  (ZP_WIN),
        .IDX_WIN (IDX_WIN),
        .ACC_WIN (ACC_WIN)
      ) cmp_i (
        .older_valid (stage_valid[i]),
        .older_wr    (held_desc[i].wr),
        .older_zp    (held_desc[i].zp),
        .new_rd      (in_rd),
        .new_zp      (in_zp),
        .hit         (stage_hit[i])
      );
    end
  endgenerate

  always_comb begin
    hazard = |stage_hit;
    issue  = in_valid && !hazard;
    stall  = in_valid && hazard;
  end

  // R3: issue and stall exclude each other and need an offer.
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(issue && stall) && (in_valid || (!issue && !stall)));

  // R3: a stall leaves stage 1 empty on the next cycle.
  a_r3_bubble_in: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stage_valid[0]);

  // R2: an issued offer occupies stage 1 on the next cycle.
  a_r2_issue_enters: assert property (@(posedge clk) disable iff (rst)
    issue |=> stage_valid[0]);

  // R8: a stall always has an occupied stage within the compared depth.
  a_r8_stall_needs_older: assert property (@(posedge clk) disable iff (rst)
    stall |-> (|stage_valid[CMP_DEPTH-1:0]));

  // R7: with equal accumulator stages, a read of A alone never stalls.
  generate
    if (ACC_WIN <= 0) begin : g_acc_chk
      a_r7_acc_free: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_rd == (RES_N'(1) << RES_A))) |-> !stall);
    end
  endgenerate
endmodule

// File: tb/fixed_slot_interlock_tb_top.sv
module fixed_slot_interlock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] M_A  = 4'b0001;
  localparam logic [3:0] M_X  = 4'b0010;
  localparam logic [3:0] M_Y  = 4'b0100;
  localparam logic [3:0] M_ZP = 4'b1000;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_rd = '0;
  logic [3:0] in_wr = '0;
  logic [7:0] in_zp = '0;
  logic       issue, stall;
  logic [7:0] stage_valid;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_slot_interlock dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rd(in_rd), .in_wr(in_wr),
    .in_zp(in_zp), .issue(issue), .stall(stall), .stage_valid(stage_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // Offer one instruction; count stall cycles until it issues.
  // Returns just after the edge that takes it into stage 1.
  task automatic offer(input logic [3:0] rd, input logic [3:0] wr,
                       input logic [7:0] zp, output int stalls);
    stalls = 0;
    @(negedge clk);
    in_valid = 1'b1; in_rd = rd; in_wr = wr; in_zp = zp;
    #1;
    while (!issue && stalls < 20) begin
      if (stall) stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  // n cycles with no offer; descriptor inputs may carry junk.
  task automatic idle(input int n, input logic [3:0] wr_junk, input logic [7:0] zp_junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_wr = wr_junk; in_zp = zp_junk; in_rd = '0;
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    int s;
    do_reset();
    #1;
    chk("R1 reset stage_valid", stage_valid, 0);
    chk("R3 idle issue", issue, 0);
    chk("R3 idle stall", stall, 0);
    offer(M_A, M_A, 8'h00, s);
    offer(M_X, M_Y, 8'h00, s);
    offer(M_ZP, M_ZP, 8'h01, s);
    chk("R1 vector before mid-run reset", stage_valid, 8'h07);
    do_reset(); #1;
    chk("R1 mid-run reset clears", stage_valid, 0);
  endtask

  task automatic t_stream();
    int s, total;
    do_reset();
    total = 0;
    for (int i = 0; i < 8; i++) begin
      offer(M_ZP, M_ZP, 8'(8'h40 + i), s);
      total += s;
    end
    chk("R2 stream stalls", total, 0);
    chk("R2 pipeline full", stage_valid, 8'hFF);
    idle(3, '0, '0);
    chk("R2 drain three", stage_valid, 8'hF8);
    do_reset();
    offer(M_A, '0, 8'h00, s);
    idle(4, '0, '0);
    chk("R2 single walks to stage 5", stage_valid, 8'h10);
    idle(4, '0, '0);
    chk("R2 single leaves after stage 8", stage_valid, 8'h00);
  endtask

  task automatic t_zp();
    int s;
    do_reset();
    offer('0, M_ZP, 8'h10, s);
    offer(M_ZP, '0, 8'h10, s);
    chk("R4 zp back-to-back stalls", s, 5);
    do_reset();
    offer('0, M_ZP, 8'h10, s);
    idle(4, '0, '0);
    offer(M_ZP, '0, 8'h10, s);
    chk("R4 zp gap 4 stalls", s, 1);
    do_reset();
    offer('0, M_ZP, 8'h10, s);
    idle(5, '0, '0);
    offer(M_ZP, '0, 8'h10, s);
    chk("R4 zp gap 5 stalls", s, 0);
    do_reset();
    offer('0, M_ZP, 8'h10, s);
    offer(M_ZP, '0, 8'h11, s);
    chk("R5 zp other address", s, 0);
  endtask

  task automatic t_index();
    int s;
    do_reset();
    offer(M_A, M_X, 8'h00, s);
    offer(M_X, M_A, 8'h00, s);
    chk("R6 X back-to-back stalls", s, 3);
    chk("R3 bubbles after stall", stage_valid, 8'h11);
    do_reset();
    offer('0, M_Y, 8'h00, s);
    idle(2, '0, '0);
    offer(M_Y, '0, 8'h00, s);
    chk("R6 Y gap 2 stalls", s, 1);
    do_reset();
    offer('0, M_Y, 8'h00, s);
    idle(3, '0, '0);
    offer(M_Y, '0, 8'h00, s);
    chk("R6 Y gap 3 stalls", s, 0);
  endtask

  task automatic t_acc_and_order();
    int s;
    do_reset();
    offer(M_X, M_A, 8'h00, s);
    offer(M_A, M_X, 8'h00, s);
    chk("R7 A write then read", s, 0);
    do_reset();
    offer(M_X, '0, 8'h00, s);
    offer('0, M_X, 8'h00, s);
    chk("R9 read then write X", s, 0);
    do_reset();
    offer('0, M_ZP, 8'h20, s);
    offer('0, M_ZP, 8'h20, s);
    chk("R9 write then write zp", s, 0);
  endtask

  task automatic t_bubble();
    int s;
    do_reset();
    idle(1, M_ZP | M_X, 8'h22);
    offer(M_ZP | M_X, '0, 8'h22, s);
    chk("R8 bubble with junk descriptor", s, 0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_zp();
    t_index();
    t_acc_and_order();
    t_bubble();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule